// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a relative near jump in one clock. It takes a 4-bit condition selector, the five arithmetic status bits (overflow, carry, zero, sign, parity), the address of the next instruction, a signed displacement and the code segment's scaled limit. From these it decides whether the jump happens and forms the destination. In protected mode it checks that destination against the segment limit. It reports one of three outcomes: the jump proceeds and the fetch stream must be refilled, the jump raises a general-protection fault with error code zero, or the jump falls through.

The same path serves unconditional relative jumps and relative calls. For those, an override input forces the condition true. Pushing a return address, decoding the instruction and producing the status bits belong to other units. A strobe on the input side launches one evaluation. Exactly one cycle later the registered result appears together with an output strobe.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid, taken, flush and gp_fault are 0 and next_ip is 0.
- R2: Every cycle with in_valid high produces exactly one cycle with out_valid high, on the next clock edge. A cycle without in_valid produces out_valid low on the next edge.
- R3: For even selector values the condition is: 0 overflow set; 2 carry set; 4 zero set; 6 carry or zero set; 8 sign set; 10 parity set; 12 sign differs from overflow; 14 zero set, or sign differs from overflow.
- R4: Each odd selector value 2k+1 gives the inverse of the condition of selector 2k. For example, 15 means sign equals overflow and zero clear.
- R5: The destination is cur_ip plus the sign-extended displacement, wrapping modulo 2^ADDR_W.
- R6: When the condition is false, taken, flush and gp_fault are 0 and next_ip equals cur_ip, whatever the limit or mode.
- R7: In protected mode (prot_mode = 1), a taken jump whose destination is greater than cs_limit sets gp_fault and keeps next_ip equal to cur_ip. A destination equal to cs_limit is allowed.
- R8: In real mode (prot_mode = 0) no limit check is done, and a taken jump never faults.
- R9: When force_take is 1, the jump is taken regardless of selector and flags.
- R10: flush is high only in an output cycle where the jump is taken without a fault, and next_ip then equals the destination. Between results it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Launches one evaluation |
| cond_code | input | 4 | Condition selector |
| force_take | input | 1 | Forces the condition true (unconditional jump or call) |
| flag_ovf | input | 1 | Overflow status bit |
| flag_carry | input | 1 | Carry status bit |
| flag_zero | input | 1 | Zero status bit |
| flag_sign | input | 1 | Sign status bit |
| flag_parity | input | 1 | Parity status bit |
| cur_ip | input | ADDR_W | Address of the following instruction |
| disp | input | DISP_W | Signed displacement |
| prot_mode | input | 1 | 1 = protected mode, limit check on |
| cs_limit | input | ADDR_W | Scaled code segment limit |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| next_ip | output | ADDR_W | Resulting instruction pointer |
| taken | output | 1 | Condition evaluated true |
| flush | output | 1 | Refill fetch stream: taken and no fault |
| gp_fault | output | 1 | General-protection fault, error code 0 |

## Verification
A wrong predicate entry shows up as an inverted taken bit, and a missed negation makes an even/odd pair agree. Either appears on the single output cycle of the offending strobe, with next_ip off by exactly the displacement. A broken limit comparison either faults on a destination equal to the limit or lets a destination one past it through. In both cases flush and gp_fault swap on that same cycle. Because the result register holds only one cycle of state, a stale or stuck result is visible at the next strobe, or through out_valid staying high in an idle cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int COND_W   = 4;
    localparam int NUM_COND = 1 << COND_W;
    localparam int NUM_BASE = NUM_COND / 2;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic zero;
        logic sign;
        logic parity;
    } arith_flags_t;

    typedef enum logic [2:0] {
        BASE_OVF      = 3'd0,
        BASE_CARRY    = 3'd1,
        BASE_ZERO     = 3'd2,
        BASE_BELOW_EQ = 3'd3,
        BASE_SIGN     = 3'd4,
        BASE_PARITY   = 3'd5,
        BASE_LESS     = 3'd6,
        BASE_LESS_EQ  = 3'd7
    } base_cond_e;

    typedef struct packed {
        logic taken;
        logic fault;
        logic flush;
    } verdict_t;

    function automatic logic base_eval(base_cond_e sel, arith_flags_t f);
        logic lt;
        lt = f.sign ^ f.ovf;
        case (sel)
            BASE_OVF:      return f.ovf;
            BASE_CARRY:    return f.carry;
            BASE_ZERO:     return f.zero;
            BASE_BELOW_EQ: return f.carry | f.zero;
            BASE_SIGN:     return f.sign;
            BASE_PARITY:   return f.parity;
            BASE_LESS:     return lt;
            default:       return f.zero | lt;
        endcase
    endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic              force_take,
    input  arith_flags_t      flags,
    output logic              cond_true
);
    logic [NUM_BASE-1:0] base_vec;
    logic [NUM_COND-1:0] pred;

    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        assign base_vec[b] = base_eval(base_cond_e'(3'(b)), flags);
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_pred
        localparam int BASE_IDX = g / 2;
        if (g % 2 == 1) begin : g_inv
            assign pred[g] = ~base_vec[BASE_IDX];
        end else begin : g_dir
            assign pred[g] = base_vec[BASE_IDX];
        end
    end

    assign cond_true = force_take | pred[code];
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 32
) (
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] cs_limit,
    output logic [ADDR_W-1:0] target,
    output logic              over_limit
);
    logic [ADDR_W-1:0] disp_ext;

    if (DISP_W < ADDR_W) begin : g_sext
        localparam int PAD_W = ADDR_W - DISP_W;
        assign disp_ext = {{PAD_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
        assign disp_ext = disp[ADDR_W-1:0];
    end

    assign target     = cur_ip + disp_ext;
    assign over_limit = target > cs_limit;
endmodule

// File: rtl/bru_verdict.sv
module bru_verdict
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              cond_true,
    input  logic              prot_mode,
    input  logic              over_limit,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [ADDR_W-1:0] target,
    output verdict_t          verdict,
    output logic [ADDR_W-1:0] ip_out
);
    always_comb begin
        verdict.taken = cond_true;
        verdict.fault = cond_true & prot_mode & over_limit;
        verdict.flush = cond_true & ~verdict.fault;
        ip_out        = verdict.flush ? target : cur_ip;
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        cond_code,
    input  logic              force_take,
    input  logic              flag_ovf,
    input  logic              flag_carry,
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic              flag_parity,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [DISP_W-1:0] disp,
    input  logic              prot_mode,
    input  logic [ADDR_W-1:0] cs_limit,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_ip,
    output logic              taken,
    output logic              flush,
    output logic              gp_fault
);
    arith_flags_t      flags;
    logic              cond_true;
    logic [ADDR_W-1:0] target;
    logic              over_limit;
    verdict_t          verdict;
    logic [ADDR_W-1:0] ip_comb;
    verdict_t          verdict_q;
    logic [ADDR_W-1:0] ip_q;
    logic              valid_q;

    assign flags = '{ovf: flag_ovf, carry: flag_carry, zero: flag_zero,
                     sign: flag_sign, parity: flag_parity};

    bru_cond_eval u_cond (
        .code       (cond_code),
        .force_take (force_take),
        .flags      (flags),
        .cond_true  (cond_true)
    );

    bru_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
        .cur_ip     (cur_ip),
        .disp       (disp),
        .cs_limit   (cs_limit),
        .target     (target),
        .over_limit (over_limit)
    );

    bru_verdict #(.ADDR_W(ADDR_W)) u_verdict (
        .cond_true  (cond_true),
        .prot_mode  (prot_mode),
        .over_limit (over_limit),
        .cur_ip     (cur_ip),
        .target     (target),
        .verdict    (verdict),
        .ip_out     (ip_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
            ip_q      <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                verdict_q <= verdict;
                ip_q      <= ip_comb;
            end else begin
                verdict_q <= '0;
            end
        end
    end

    assign out_valid = valid_q;
    assign next_ip   = ip_q;
    assign taken     = verdict_q.taken;
    assign flush     = verdict_q.flush;
    assign gp_fault  = verdict_q.fault;
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              force_take,
    input logic              prot_mode,
    input logic [ADDR_W-1:0] cur_ip,
    input logic [ADDR_W-1:0] cs_limit,
    input logic              out_valid,
    input logic [ADDR_W-1:0] next_ip,
    input logic              taken,
    input logic              flush,
    input logic              gp_fault
);
    // R1: outputs cleared after a reset cycle
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !taken && !flush && !gp_fault && next_ip == '0));

    // R2: one result per strobe, on the next edge
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: false condition falls through
    a_r6_fallthrough: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taken || (next_ip == $past(cur_ip) && !flush && !gp_fault)));

    // R7: fault keeps the pointer
    a_r7_fault_holds_ip: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!gp_fault || (taken && !flush && next_ip == $past(cur_ip))));

    // R7: a redirect in protected mode stays within the limit
    a_r7_within_limit: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!flush || !$past(prot_mode) || next_ip <= $past(cs_limit)));

    // R8: real mode never faults
    a_r8_real_no_fault: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !prot_mode) |=> !gp_fault);

    // R9: override forces taken
    a_r9_force: assert property (@(posedge clk) disable iff (rst)
        (in_valid && force_take) |=> taken);

    // R10: flush only with a valid, taken, fault-free result
    a_r10_flush_qual: assert property (@(posedge clk) disable iff (rst)
        flush |-> (out_valid && taken && !gp_fault));
    a_r10_outcome_onehot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({flush, gp_fault}));
endmodule

bind branch_resolve_unit bru_checker #(.ADDR_W(ADDR_W)) u_bru_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .force_take (force_take),
    .prot_mode  (prot_mode),
    .cur_ip     (cur_ip),
    .cs_limit   (cs_limit),
    .out_valid  (out_valid),
    .next_ip    (next_ip),
    .taken      (taken),
    .flush      (flush),
    .gp_fault   (gp_fault)
);

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
    localparam int ADDR_W = 32;
    localparam int DISP_W = 32;
    localparam int NVEC   = 26;

    // {code[3:0], ovf, carry, zero, sign, parity, expected_taken}
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {4'h0, 5'b10000, 1'b1}, {4'h0, 5'b01111, 1'b0},
        {4'h1, 5'b10000, 1'b0}, {4'h1, 5'b00000, 1'b1},
        {4'h2, 5'b01000, 1'b1}, {4'h3, 5'b01000, 1'b0},
        {4'h4, 5'b00100, 1'b1}, {4'h5, 5'b00100, 1'b0},
        {4'h6, 5'b00100, 1'b1}, {4'h6, 5'b01000, 1'b1},
        {4'h6, 5'b10011, 1'b0}, {4'h7, 5'b00000, 1'b1},
        {4'h8, 5'b00010, 1'b1}, {4'h9, 5'b00010, 1'b0},
        {4'hA, 5'b00001, 1'b1}, {4'hB, 5'b00001, 1'b0},
        {4'hC, 5'b10000, 1'b1}, {4'hC, 5'b10010, 1'b0},
        {4'hD, 5'b00010, 1'b0}, {4'hD, 5'b10010, 1'b1},
        {4'hE, 5'b00100, 1'b1}, {4'hE, 5'b00010, 1'b1},
        {4'hE, 5'b10010, 1'b0}, {4'hF, 5'b10010, 1'b1},
        {4'hF, 5'b10110, 1'b0}, {4'hF, 5'b00010, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [3:0]        cond_code = '0;
    logic              force_take = 1'b0;
    logic              flag_ovf = 1'b0, flag_carry = 1'b0, flag_zero = 1'b0;
    logic              flag_sign = 1'b0, flag_parity = 1'b0;
    logic [ADDR_W-1:0] cur_ip = '0;
    logic [DISP_W-1:0] disp = '0;
    logic              prot_mode = 1'b0;
    logic [ADDR_W-1:0] cs_limit = '0;
    logic              out_valid;
    logic [ADDR_W-1:0] next_ip;
    logic              taken, flush, gp_fault;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    branch_resolve_unit #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_branch_resolve_unit (
        .clk, .rst, .in_valid, .cond_code, .force_take,
        .flag_ovf, .flag_carry, .flag_zero, .flag_sign, .flag_parity,
        .cur_ip, .disp, .prot_mode, .cs_limit,
        .out_valid, .next_ip, .taken, .flush, .gp_fault
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] got,
                         input logic [ADDR_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Launch one evaluation; returns with outputs of that strobe visible.
    task automatic launch(input logic [3:0] code, input logic frc,
                          input logic [4:0] fl, input logic pm,
                          input logic [ADDR_W-1:0] ip,
                          input logic [DISP_W-1:0] d,
                          input logic [ADDR_W-1:0] lim);
        @(negedge clk);
        cond_code  = code;
        force_take = frc;
        {flag_ovf, flag_carry, flag_zero, flag_sign, flag_parity} = fl;
        prot_mode  = pm;
        cur_ip     = ip;
        disp       = d;
        cs_limit   = lim;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic t,
                                 input logic f, input logic g,
                                 input logic [ADDR_W-1:0] ip);
        check({req, " out_valid"}, ADDR_W'(out_valid), 1);
        check({req, " taken"},     ADDR_W'(taken), ADDR_W'(t));
        check({req, " flush"},     ADDR_W'(flush), ADDR_W'(f));
        check({req, " gp_fault"},  ADDR_W'(gp_fault), ADDR_W'(g));
        check({req, " next_ip"},   next_ip, ip);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", ADDR_W'(out_valid), 0);
        check("R1 flush", ADDR_W'(flush), 0);
        check("R1 gp_fault", ADDR_W'(gp_fault), 0);
        check("R1 next_ip", next_ip, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release out_valid", ADDR_W'(out_valid), 0);

        // R3/R4: predicate table, real mode
        for (int i = 0; i < NVEC; i++) begin
            logic exp_t;
            exp_t = VEC[i][0];
            launch(VEC[i][9:6], 1'b0, VEC[i][5:1], 1'b0,
                   32'h0000_1000, 32'h0000_0020, 32'h0);
            expect_result(VEC[i][6] ? "R4 odd code" : "R3 even code",
                          exp_t, exp_t, 1'b0,
                          exp_t ? 32'h0000_1020 : 32'h0000_1000);
        end

        // R2: idle cycle yields no result
        @(negedge clk);
        check("R2 idle out_valid", ADDR_W'(out_valid), 0);
        check("R10 idle flush", ADDR_W'(flush), 0);

        // R5: negative displacement and wrap
        launch(4'h0, 1'b1, 5'b0, 1'b0, 32'h0000_1000, 32'hFFFF_FFF0, 32'h0);
        expect_result("R5 negative", 1'b1, 1'b1, 1'b0, 32'h0000_0FF0);
        launch(4'h0, 1'b1, 5'b0, 1'b0, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0);
        expect_result("R5 wrap", 1'b1, 1'b1, 1'b0, 32'h0000_0010);

        // R9: override beats a false condition (code 0, overflow clear)
        launch(4'h0, 1'b1, 5'b0, 1'b1, 32'h0000_0100, 32'h0000_0004, 32'hFFFF_FFFF);
        expect_result("R9 force", 1'b1, 1'b1, 1'b0, 32'h0000_0104);

        // R7: destination equal to limit is allowed
        launch(4'h0, 1'b1, 5'b0, 1'b1, 32'h0000_1F00, 32'h0000_0100, 32'h0000_2000);
        expect_result("R7 at limit", 1'b1, 1'b1, 1'b0, 32'h0000_2000);
        // R7: one past limit faults, pointer kept
        launch(4'h0, 1'b1, 5'b0, 1'b1, 32'h0000_1F00, 32'h0000_0101, 32'h0000_2000);
        expect_result("R7 over limit", 1'b1, 1'b0, 1'b1, 32'h0000_1F00);
        // R7: conditional taken jump over limit also faults
        launch(4'h4, 1'b0, 5'b00100, 1'b1, 32'h0000_1F00, 32'h0000_0200, 32'h0000_2000);
        expect_result("R7 cond over limit", 1'b1, 1'b0, 1'b1, 32'h0000_1F00);
        // R7: wrapped destination below the limit is fine
        launch(4'h0, 1'b1, 5'b0, 1'b1, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_2000);
        expect_result("R7 wrap within", 1'b1, 1'b1, 1'b0, 32'h0000_0010);

        // R6: not taken in protected mode beyond limit: no fault
        launch(4'h4, 1'b0, 5'b00000, 1'b1, 32'h0000_1F00, 32'h0000_0200, 32'h0000_2000);
        expect_result("R6 not taken prot", 1'b0, 1'b0, 1'b0, 32'h0000_1F00);

        // R8: real mode ignores the limit
        launch(4'h0, 1'b1, 5'b0, 1'b0, 32'h0000_1F00, 32'h0000_0200, 32'h0000_2000);
        expect_result("R8 real mode", 1'b1, 1'b1, 1'b0, 32'h0000_2100);

        // R10: flush is a one-cycle pulse after an isolated result
        @(negedge clk);
        check("R10 flush dropped", ADDR_W'(flush), 0);
        check("R2 out_valid dropped", ADDR_W'(out_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule